// File: doc/BRIEF.md
# PAM4 Transmit Symbol Mapper

This block produces the 2-bit symbol stream that a PAM4 pattern generator sends to its output driver. A built-in pseudo-random sequence source (PRBS31) supplies two bits per symbol. The first of the two becomes the MSB lane and the second becomes the LSB lane. Each lane pair then passes through several stages in order. First comes a per-lane inversion. Then an optional Gray mapping and an optional mod-4 precoder. Then a second per-lane inversion. Last, a programmable delay on the MSB lane skews it against the LSB lane. The result is a symbol from 0 to 3, with the MSB as the high-order bit.

The symbol leaves on a valid/ready stream. A new symbol is produced only when `run` is high and the output register is empty or being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the symbol is held unchanged and no internal state advances. Back-pressure therefore never drops or repeats a symbol. The coding controls are plain level inputs, sampled on the cycle a symbol is produced. The skew setting is staged: `skew_in` is copied into the active skew only on a `skew_load` strobe.

Top module: `pam4_sym_mapper`

## Requirements
- R1: After reset `out_valid` is 0, the sequence state is all ones, the precoder memory is 0, the active skew is 0 and every delay-line entry is 0.
- R2: A symbol is produced (a "fire") on a clock edge where `run`=1 and either `out_valid`=0 or `out_ready`=1. On a fire, `out_valid` becomes 1 and `out_sym` takes the new symbol. Without a fire, an accepted symbol (`out_ready`=1) clears `out_valid`. While `out_valid`=1 and `out_ready`=0, `out_sym` and `out_valid` hold.
- R3: Each fire takes two sequence steps from the 31-bit state s. A step computes b = s[30] XOR s[27] and replaces the state with {s[29:0], b}. The first step's b is the MSB lane bit and the second step's b is the LSB lane bit.
- R4: `inv_msb_pre` and `inv_lsb_pre` each invert their own lane before the coding stages.
- R5: With `gray_en`=1 the pair (MSB,LSB) maps to level 00→0, 01→1, 11→2, 10→3. With `gray_en`=0 the level is {MSB,LSB}.
- R6: With `prec_en`=1 the coded level is P = (G − M) mod 4, where M is the precoder memory. M becomes P on that fire. With `prec_en`=0 the level passes unchanged and M holds.
- R7: `inv_msb_post` and `inv_lsb_post` invert bit 1 and bit 0 of the coded level respectively.
- R8: With active skew k, `out_sym[1]` is the post-inversion MSB of the fire k fires earlier (0 where no such fire exists since reset). `out_sym[0]` is always the current fire's LSB.
- R9: `skew_in` has no effect until a cycle with `skew_load`=1, which makes it the active skew from the next edge on. Values above SKEW_MAX load as SKEW_MAX.
- R10: `prec_clr`=1 sets M to 0 at that edge. If a fire happens on the same edge, the symbol uses the old M.
- R11: The coding controls take effect on the symbol of the fire in which they are sampled, and in any combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Allow symbol production |
| inv_msb_pre | input | 1 | Invert MSB lane before coding |
| inv_lsb_pre | input | 1 | Invert LSB lane before coding |
| gray_en | input | 1 | Enable Gray mapping |
| prec_en | input | 1 | Enable mod-4 precoder |
| inv_msb_post | input | 1 | Invert MSB after coding |
| inv_lsb_post | input | 1 | Invert LSB after coding |
| prec_clr | input | 1 | Synchronous clear of precoder memory |
| skew_in | input | SKEW_W | Staged MSB skew in symbols |
| skew_load | input | 1 | Copy `skew_in` into active skew |
| out_ready | input | 1 | Stream consumer ready |
| out_valid | output | 1 | Stream symbol valid |
| out_sym | output | 2 | Output symbol, MSB is bit 1 |

## Verification
The hardest state to reach is one where several things meet at once. The delay line must be filled with MSB history taken under changing post-inversion settings, the precoder memory must be non-zero, and a stall must coincide with a `prec_clr` or `skew_load`. Only then do the hold, clear-priority and shadow rules all matter at the same edge. The stimulus gets there with directed runs at the largest skew, with `skew_in` toggled without a load. A long random phase then mixes ready stalls, clears and loads with random control settings. Every cycle is compared against a bench model of the sequence, the coding and the delay line.

// File: rtl/pam4_map_pkg.sv
package pam4_map_pkg;

  typedef struct packed {
    logic msb;
    logic lsb;
  } lane_pair_t;

  typedef struct packed {
    logic inv_msb_pre;
    logic inv_lsb_pre;
    logic gray_en;
    logic prec_en;
    logic inv_msb_post;
    logic inv_lsb_post;
  } code_cfg_t;

  // Gray level from a lane pair: 00->0, 01->1, 11->2, 10->3
  function automatic logic [1:0] gray_level(lane_pair_t p);
    return {p.msb, p.msb ^ p.lsb};
  endfunction

endpackage

// File: rtl/pam4_prbs_src.sv
module pam4_prbs_src #(
  parameter int LEN  = 31,
  parameter int TAP  = 28,
  parameter int BITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  output logic [BITS-1:0] bits
);
  logic [LEN-1:0] state, nxt;

  always_comb begin
    logic [LEN-1:0] t;
    logic b;
    t = state;
    bits = '0;
    for (int i = 0; i < BITS; i++) begin
      b = t[LEN-1] ^ t[TAP-1];
      bits[BITS-1-i] = b;
      t = {t[LEN-2:0], b};
    end
    nxt = t;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= '1;
    else if (advance) state <= nxt;
  end

  always @(posedge clk)
    if (rst_n) AST_PRBS_LIVE: assert (state != '0); // R3

  AST_PRBS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(state)); // R2
endmodule

// File: rtl/pam4_code_stage.sv
module pam4_code_stage
  import pam4_map_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  input  logic       clr,
  input  code_cfg_t  cfg,
  input  lane_pair_t pair_in,
  output logic [1:0] level_out
);
  lane_pair_t pre;
  logic [1:0] g, p, mem;

  always_comb begin
    pre.msb = pair_in.msb ^ cfg.inv_msb_pre;
    pre.lsb = pair_in.lsb ^ cfg.inv_lsb_pre;
    g = cfg.gray_en ? gray_level(pre) : {pre.msb, pre.lsb};
    p = cfg.prec_en ? (g - mem) : g;
    level_out = p ^ {cfg.inv_msb_post, cfg.inv_lsb_post};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)              mem <= '0;
    else if (advance && cfg.prec_en) mem <= p;
  end

  AST_PREC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(advance && cfg.prec_en)) |=> $stable(mem)); // R6
  AST_PREC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mem == 2'd0)); // R10
endmodule

// File: rtl/pam4_msb_skew.sv
module pam4_msb_skew #(
  parameter int SKEW_MAX = 15,
  localparam int SKEW_W  = $clog2(SKEW_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              msb_in,
  input  logic [SKEW_W-1:0] skew_in,
  input  logic              skew_load,
  output logic              msb_out
);
  logic [SKEW_W-1:0] active;
  logic [SKEW_MAX-1:0] hist;
  logic [SKEW_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) active <= '0;
    else if (skew_load)
      active <= (skew_in > SKEW_W'(SKEW_MAX)) ? SKEW_W'(SKEW_MAX) : skew_in;
  end

  generate
    for (genvar i = 0; i < SKEW_MAX; i++) begin : g_tap
      always_ff @(posedge clk) begin
        if (!rst_n)     hist[i] <= 1'b0;
        else if (shift) hist[i] <= (i == 0) ? msb_in : hist[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_comb begin
    idx = active - 1'b1;
    msb_out = (active == '0) ? msb_in : hist[idx];
  end

  AST_SKEW_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    !skew_load |=> $stable(active)); // R9
  AST_SKEW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active <= SKEW_W'(SKEW_MAX)); // R9
endmodule

// File: rtl/pam4_sym_mapper.sv
module pam4_sym_mapper
  import pam4_map_pkg::*;
#(
  parameter int SKEW_MAX = 15,
  localparam int SKEW_W  = $clog2(SKEW_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              inv_msb_pre,
  input  logic              inv_lsb_pre,
  input  logic              gray_en,
  input  logic              prec_en,
  input  logic              inv_msb_post,
  input  logic              inv_lsb_post,
  input  logic              prec_clr,
  input  logic [SKEW_W-1:0] skew_in,
  input  logic              skew_load,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [1:0]        out_sym
);
  logic       fire;
  logic [1:0] raw;
  lane_pair_t pair;
  code_cfg_t  cfg;
  logic [1:0] coded;
  logic       msb_sk;

  assign fire = run && (!out_valid || out_ready);
  assign pair = '{msb: raw[1], lsb: raw[0]};
  assign cfg  = '{inv_msb_pre: inv_msb_pre, inv_lsb_pre: inv_lsb_pre,
                  gray_en: gray_en, prec_en: prec_en,
                  inv_msb_post: inv_msb_post, inv_lsb_post: inv_lsb_post};

  pam4_prbs_src #(.LEN(31), .TAP(28), .BITS(2)) u_src (
    .clk(clk), .rst_n(rst_n), .advance(fire), .bits(raw));

  pam4_code_stage u_code (
    .clk(clk), .rst_n(rst_n), .advance(fire), .clr(prec_clr),
    .cfg(cfg), .pair_in(pair), .level_out(coded));

  pam4_msb_skew #(.SKEW_MAX(SKEW_MAX)) u_skew (
    .clk(clk), .rst_n(rst_n), .shift(fire), .msb_in(coded[1]),
    .skew_in(skew_in), .skew_load(skew_load), .msb_out(msb_sk));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sym   <= 2'd0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_sym   <= {msb_sk, coded[0]};
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !out_valid) |=> !out_valid); // R2
  AST_FIRE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> out_valid); // R2
endmodule

// File: tb/pam4_sym_mapper_bench.sv
module pam4_sym_mapper_bench;
  localparam int SKEW_MAX = 15;
  localparam int SW = 4;

  logic clk = 0, rst_n = 0;
  logic run = 0, out_ready = 0, prec_clr = 0, skew_load = 0;
  logic [5:0] cfg = '0; // {msb_pre, lsb_pre, gray, prec, msb_post, lsb_post}
  logic [SW-1:0] skew_in = '0;
  logic out_valid;
  logic [1:0] out_sym;

  always #4 clk = ~clk;

  pam4_sym_mapper #(.SKEW_MAX(SKEW_MAX)) u_pam4_sym_mapper (
    .clk(clk), .rst_n(rst_n), .run(run),
    .inv_msb_pre(cfg[5]), .inv_lsb_pre(cfg[4]), .gray_en(cfg[3]),
    .prec_en(cfg[2]), .inv_msb_post(cfg[1]), .inv_lsb_post(cfg[0]),
    .prec_clr(prec_clr), .skew_in(skew_in), .skew_load(skew_load),
    .out_ready(out_ready), .out_valid(out_valid), .out_sym(out_sym));

  int checks = 0, fails = 0;
  logic [30:0] m_lfsr;
  logic [1:0]  m_mem;
  logic [SKEW_MAX-1:0] m_hist;
  int m_skew;
  logic m_valid;
  logic [1:0] m_sym;

  task automatic chk(string tag, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got valid/sym=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic lfsr_step();
    logic b;
    b = m_lfsr[30] ^ m_lfsr[27];
    m_lfsr = {m_lfsr[29:0], b};
    return b;
  endfunction

  function automatic void model_fire();
    logic m, l, q1;
    logic [1:0] g, p, q;
    m = lfsr_step() ^ cfg[5];
    l = lfsr_step() ^ cfg[4];
    g = cfg[3] ? {m, m ^ l} : {m, l};
    p = cfg[2] ? 2'(g - m_mem) : g;
    if (cfg[2]) m_mem = p;
    q = p ^ cfg[1:0];
    q1 = (m_skew == 0) ? q[1] : m_hist[m_skew-1];
    m_hist = {m_hist[SKEW_MAX-2:0], q[1]};
    m_sym = {q1, q[0]};
    m_valid = 1'b1;
  endfunction

  // drive one cycle, update model, sample after the edge
  task automatic step(string tag, logic r, logic rdy, logic [5:0] c,
                      logic clr, logic [SW-1:0] sk, logic ld);
    run = r; out_ready = rdy; cfg = c; prec_clr = clr; skew_in = sk; skew_load = ld;
    if (r && (!m_valid || rdy)) model_fire();
    else if (rdy) m_valid = 1'b0;
    if (clr) m_mem = 2'd0;
    if (ld) m_skew = (int'(sk) > SKEW_MAX) ? SKEW_MAX : int'(sk);
    @(posedge clk); #2;
    chk(tag, {out_valid, m_valid ? out_sym : 2'b00}, {m_valid, m_valid ? m_sym : 2'b00});
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    m_lfsr = '1; m_mem = 0; m_hist = '0; m_skew = 0; m_valid = 0; m_sym = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk("R1 reset", {out_valid, 2'b00}, 3'b000);
    // R3 raw sequence, all coding off
    for (int i = 0; i < 40; i++) step("R3", 1, 1, 6'b000000, 0, 0, 0);
    // R4 pre-inversion per lane
    for (int i = 0; i < 20; i++) step("R4", 1, 1, {i[0], i[1], 4'b0000}, 0, 0, 0);
    // R5 Gray mapping
    for (int i = 0; i < 20; i++) step("R5", 1, 1, 6'b001000, 0, 0, 0);
    // R6 precoder with and without Gray
    for (int i = 0; i < 30; i++) step("R6", 1, 1, {2'b00, i[2], 1'b1, 2'b00}, 0, 0, 0);
    // R7 post-inversion
    for (int i = 0; i < 20; i++) step("R7", 1, 1, {4'b0010, i[1], i[0]}, 0, 0, 0);
    // R10 clear while firing and while idle
    step("R10", 1, 1, 6'b000100, 1, 0, 0);
    for (int i = 0; i < 5; i++) step("R10", 1, 1, 6'b001100, 0, 0, 0);
    step("R10", 0, 1, 6'b000100, 1, 0, 0);
    for (int i = 0; i < 5; i++) step("R10", 1, 1, 6'b000100, 0, 0, 0);
    // R8 maximum skew
    step("R8", 1, 1, 6'b000000, 0, 4'd15, 1);
    for (int i = 0; i < 40; i++) step("R8", 1, 1, {4'b0000, i[3], 1'b0}, 0, 4'd15, 0);
    // R9 skew_in without load has no effect
    for (int i = 0; i < 20; i++) step("R9", 1, 1, 6'b000000, 0, SW'(i), 0);
    step("R9", 1, 1, 6'b000000, 0, 4'd3, 1);
    for (int i = 0; i < 10; i++) step("R9", 1, 1, 6'b000000, 0, 4'd9, 0);
    // R2 stalls and idle drain
    for (int i = 0; i < 6; i++) step("R2", 1, 0, 6'b001111, 0, 0, 0);
    step("R2", 0, 1, 6'b000000, 0, 0, 0);
    step("R2", 0, 1, 6'b000000, 0, 0, 0);
    step("R2", 1, 0, 6'b000000, 0, 0, 0);
    step("R2", 1, 1, 6'b000000, 0, 0, 0);
    // R11 random mix
    for (int i = 0; i < 3000; i++)
      step("R11", ($urandom % 8) != 0, ($urandom % 4) != 0, 6'($urandom),
           ($urandom % 16) == 0, SW'($urandom), ($urandom % 32) == 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule